// File: doc/BRIEF.md
# Replica-Timed Adaptive Clock Generator

This block produces a free-running core clock whose two half-periods are each measured by an external tunable delay chain that mimics the processor's critical path. When the output clock is high, the block waits for the high-time replica pulse and then pulls the clock low. When the clock is low, it waits for the low-time replica pulse and then raises the clock on a reference phase. Because the replica is supplied from the same rippling rail as the core, the period stretches and shrinks cycle by cycle with the supply. The average frequency therefore follows the average replica delay and nothing else.

The block runs on a fast sampling clock. The replica pulses arrive asynchronously, so each passes through a two-flop synchronizer followed by an edge detector. A rising edge is placed on the first reference phase that follows the synchronized pulse. The block drives separate delay codes for the high and low replica paths. These codes are picked per supply mode, clamped to the legal delay range, and changed only when the output clock falls, so no runt pulse can occur. A watchdog counts fast-clock cycles since the last rising edge. If the clock stalls, the watchdog forces a rising edge and latches an error flag.

Top module: `acg_clk_gen`

## Requirements
- R1: While reset is asserted and right after it is released, `clk_adapt` is 0, `wd_error` is 0, and both delay codes are 124.
- R2: A high-time replica pulse that arrives while `clk_adapt` is high drives `clk_adapt` low at the third fast-clock rising edge that samples the pulse, the first of those edges being the one that captures it.
- R3: A low-time replica pulse that arrives while `clk_adapt` is low captures `ref_phase` at the third edge that samples the pulse, and sets the target to that value plus one, modulo 16. `clk_adapt` then rises at the first later edge at which `ref_phase` equals the target.
- R4: A low-time pulse while the clock is high, and a high-time pulse while the clock is low, have no effect on `clk_adapt` or on the delay codes.
- R5: Mode m takes its high code from `hi_delay_cfg[7*m +: 7]` and its low code from `lo_delay_cfg[7*m +: 7]`. The output codes reload from the current `mode_sel` only at the edge where `clk_adapt` falls. A mode change while the clock is high leaves the codes unchanged.
- R6: A configured code below 4 is driven as 4. A configured code above 124 is driven as 124. Codes between these limits pass through unchanged.
- R7: If `wd_limit` is L (non-zero) and L edges pass after a rising edge with no further rising edge, then at edge L+1 `clk_adapt` is driven low and `wd_error` is set. At edge L+2 `clk_adapt` rises, whatever `ref_phase` holds.
- R8: Once set, `wd_error` stays at 1 until reset.
- R9: `wd_limit` equal to 0 disables the watchdog. The clock can stay in one state indefinitely without setting `wd_error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rep_hi_pulse | input | 1 | High-time replica pulse (asynchronous) |
| rep_lo_pulse | input | 1 | Low-time replica pulse (asynchronous) |
| ref_phase | input | 4 | Index of the current reference phase |
| mode_sel | input | 2 | Current supply mode |
| hi_delay_cfg | input | 28 | High-path delay code per mode, 7 bits each |
| lo_delay_cfg | input | 28 | Low-path delay code per mode, 7 bits each |
| wd_limit | input | 16 | Watchdog timeout in fast cycles (0 disables it) |
| clk_adapt | output | 1 | Adaptive clock output |
| hi_delay_code | output | 7 | Delay code driven to the high replica path |
| lo_delay_code | output | 7 | Delay code driven to the low replica path |
| wd_error | output | 1 | Sticky watchdog error flag |

## Verification
The bench numbers each fast-clock edge from the edge that first captures a pulse. A fall and a code reload are due on edge 3. A rise is due on the first edge after edge 3 at which the phase the bench generates equals the phase captured on edge 3 plus one. Watchdog events are counted from the last rising edge and are due on edges L+1 and L+2. The bench changes its phase counter only on falling edges, drives pulses just after rising edges and reads the outputs 1 ns after each rising edge. Every event therefore lands on exactly one numbered edge. The bench also checks that the clock holds its level on every edge before the due one.

// File: rtl/acg_pkg.sv
`timescale 1ns/1ps
package acg_pkg;
    typedef enum logic [1:0] {
        S_HIGH  = 2'd0,
        S_LOW   = 2'd1,
        S_ARM   = 2'd2,
        S_FORCE = 2'd3
    } acg_state_e;
endpackage

// File: rtl/acg_pulse_sync.sv
`timescale 1ns/1ps
module acg_pulse_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_async,
    output logic pulse_edge
);
    logic [STAGES:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[STAGES-1:0], pulse_async};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign pulse_edge = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/acg_code_sel.sv
`timescale 1ns/1ps
module acg_code_sel #(
    parameter int NUM_MODES = 4,
    parameter int CODE_W    = 7,
    parameter int CODE_MIN  = 4,
    parameter int CODE_MAX  = 124,
    localparam int MODE_W   = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
    input  logic [NUM_MODES*CODE_W-1:0] cfg,
    input  logic [MODE_W-1:0]           mode,
    output logic [CODE_W-1:0]           code
);
    logic [CODE_W-1:0] clamped [NUM_MODES];

    for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
        logic [CODE_W-1:0] field;
        assign field = cfg[g*CODE_W +: CODE_W];
        always_comb begin
            if (field < CODE_W'(CODE_MIN))      clamped[g] = CODE_W'(CODE_MIN);
            else if (field > CODE_W'(CODE_MAX)) clamped[g] = CODE_W'(CODE_MAX);
            else                                clamped[g] = field;
        end
    end

    always_comb begin
        code = clamped[0];
        for (int m = 1; m < NUM_MODES; m++) begin
            if (mode == MODE_W'(m)) code = clamped[m];
        end
    end
endmodule

// File: rtl/acg_watchdog.sv
`timescale 1ns/1ps
module acg_watchdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            armed,
    input  logic [WD_W-1:0] limit,
    output logic            timeout
);
    logic [WD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)               cnt_d = '0;
        else if (cnt_q != '1)    cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign timeout = armed && (limit != '0) && (cnt_q >= limit);
endmodule

// File: rtl/acg_clk_gen.sv
`timescale 1ns/1ps
module acg_clk_gen #(
    parameter int NUM_PHASES  = 16,
    parameter int NUM_MODES   = 4,
    parameter int CODE_W      = 7,
    parameter int CODE_MIN    = 4,
    parameter int CODE_MAX    = 124,
    parameter int WD_W        = 16,
    parameter int SYNC_STAGES = 2,
    localparam int PH_W       = $clog2(NUM_PHASES),
    localparam int MODE_W     = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
    localparam int CFG_W      = NUM_MODES * CODE_W
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              rep_hi_pulse,
    input  logic              rep_lo_pulse,
    input  logic [PH_W-1:0]   ref_phase,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic [CFG_W-1:0]  hi_delay_cfg,
    input  logic [CFG_W-1:0]  lo_delay_cfg,
    input  logic [WD_W-1:0]   wd_limit,
    output logic              clk_adapt,
    output logic [CODE_W-1:0] hi_delay_code,
    output logic [CODE_W-1:0] lo_delay_code,
    output logic              wd_error
);
    import acg_pkg::*;

    typedef struct packed {
        acg_state_e        state;
        logic              clk;
        logic              err;
        logic [PH_W-1:0]   sel;
        logic [CODE_W-1:0] hi_code;
        logic [CODE_W-1:0] lo_code;
    } acg_regs_t;

    acg_regs_t r_d, r_q;

    logic hi_edge, lo_edge, timeout, rise_now;
    logic [CODE_W-1:0] hi_pick, lo_pick;

    acg_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync_hi (
        .clk(clk_fast), .rst_n(rst_n), .pulse_async(rep_hi_pulse), .pulse_edge(hi_edge)
    );
    acg_pulse_sync #(.STAGES(SYNC_STAGES)) u_sync_lo (
        .clk(clk_fast), .rst_n(rst_n), .pulse_async(rep_lo_pulse), .pulse_edge(lo_edge)
    );

    acg_code_sel #(.NUM_MODES(NUM_MODES), .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX))
        u_sel_hi (.cfg(hi_delay_cfg), .mode(mode_sel), .code(hi_pick));
    acg_code_sel #(.NUM_MODES(NUM_MODES), .CODE_W(CODE_W), .CODE_MIN(CODE_MIN), .CODE_MAX(CODE_MAX))
        u_sel_lo (.cfg(lo_delay_cfg), .mode(mode_sel), .code(lo_pick));

    acg_watchdog #(.WD_W(WD_W)) u_wd (
        .clk(clk_fast), .rst_n(rst_n), .clear(rise_now),
        .armed(r_q.state != S_FORCE), .limit(wd_limit), .timeout(timeout)
    );

    always_comb begin
        r_d = r_q;
        if (timeout) begin
            r_d.state = S_FORCE;
            r_d.clk   = 1'b0;
            r_d.err   = 1'b1;
            if (r_q.clk) begin
                r_d.hi_code = hi_pick;
                r_d.lo_code = lo_pick;
            end
        end else begin
            case (r_q.state)
                S_HIGH: begin
                    if (hi_edge) begin
                        r_d.state   = S_LOW;
                        r_d.clk     = 1'b0;
                        r_d.hi_code = hi_pick;
                        r_d.lo_code = lo_pick;
                    end
                end
                S_LOW: begin
                    if (lo_edge) begin
                        r_d.state = S_ARM;
                        r_d.sel   = (ref_phase == PH_W'(NUM_PHASES - 1)) ? '0 : ref_phase + 1'b1;
                    end
                end
                S_ARM: begin
                    if (ref_phase == r_q.sel) begin
                        r_d.state = S_HIGH;
                        r_d.clk   = 1'b1;
                    end
                end
                default: begin
                    r_d.state = S_HIGH;
                    r_d.clk   = 1'b1;
                end
            endcase
        end
    end

    assign rise_now = r_d.clk & ~r_q.clk;

    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= S_LOW;
            r_q.clk     <= 1'b0;
            r_q.err     <= 1'b0;
            r_q.sel     <= '0;
            r_q.hi_code <= CODE_W'(CODE_MAX);
            r_q.lo_code <= CODE_W'(CODE_MAX);
        end else begin
            r_q <= r_d;
        end
    end

    assign clk_adapt     = r_q.clk;
    assign hi_delay_code = r_q.hi_code;
    assign lo_delay_code = r_q.lo_code;
    assign wd_error      = r_q.err;

    assert_fall_cause_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $fell(r_q.clk) |-> ($past(hi_edge) || $past(timeout)));
    assert_rise_on_phase_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        ($rose(r_q.clk) && $past(r_q.state) == S_ARM) |-> ($past(ref_phase) == $past(r_q.sel)));
    assert_code_hold_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (!$stable(r_q.hi_code) || !$stable(r_q.lo_code)) |-> $fell(r_q.clk));
    assert_code_range_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (hi_delay_code >= CODE_W'(CODE_MIN)) && (hi_delay_code <= CODE_W'(CODE_MAX)) &&
        (lo_delay_code >= CODE_W'(CODE_MIN)) && (lo_delay_code <= CODE_W'(CODE_MAX)));
    assert_forced_rise_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $past(timeout) |-> (!r_q.clk && r_q.err));
    assert_err_sticky_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        r_q.err |=> r_q.err);
endmodule

// File: tb/acg_clk_gen_tb.sv
`timescale 1ns/1ps
module acg_clk_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rep_hi = 1'b0, rep_lo = 1'b0;
    logic [3:0]  ph = 4'd0;
    logic [1:0]  mode = 2'd0;
    logic [27:0] hi_cfg, lo_cfg;
    logic [15:0] wd_limit = 16'd1000;
    logic        clk_adapt, wd_error;
    logic [6:0]  hi_code, lo_code;
    bit          ph_run = 1'b1;
    int          ph_div = 1, div_cnt = 0;
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (ph_run) begin
            if (div_cnt >= ph_div - 1) begin div_cnt <= 0; ph <= ph + 4'd1; end
            else div_cnt <= div_cnt + 1;
        end
    end

    acg_clk_gen u_dut (
        .clk_fast(clk), .rst_n(rst_n), .rep_hi_pulse(rep_hi), .rep_lo_pulse(rep_lo),
        .ref_phase(ph), .mode_sel(mode), .hi_delay_cfg(hi_cfg), .lo_delay_cfg(lo_cfg),
        .wd_limit(wd_limit), .clk_adapt(clk_adapt), .hi_delay_code(hi_code),
        .lo_delay_code(lo_code), .wd_error(wd_error)
    );

    function automatic int clampc(int v);
        return (v < 4) ? 4 : ((v > 124) ? 124 : v);
    endfunction
    function automatic int exp_hi(int m); return clampc(int'(hi_cfg[7*m +: 7])); endfunction
    function automatic int exp_lo(int m); return clampc(int'(lo_cfg[7*m +: 7])); endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edge1();
        @(posedge clk); #1;
    endtask

    // R2 / R5: fall on edge 3, codes reload there
    task automatic do_fall();
        bit ok = 1'b1;
        @(negedge clk); rep_hi = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            edge1();
            if (i == 1) rep_hi = 1'b0;
            if (i < 3 && clk_adapt !== 1'b1) ok = 1'b0;
        end
        check(ok && clk_adapt === 1'b0, "R2 fall", int'(clk_adapt), 0);
        check(int'(hi_code) == exp_hi(mode), "R5/R6 hi code", int'(hi_code), exp_hi(mode));
        check(int'(lo_code) == exp_lo(mode), "R5/R6 lo code", int'(lo_code), exp_lo(mode));
    endtask

    // R3: rise on first edge after edge 3 with phase == captured+1
    task automatic do_rise();
        bit ok = 1'b1;
        int sel = -1;
        bit hit = 1'b0;
        @(negedge clk); rep_lo = 1'b1;
        for (int i = 1; i < 120 && !hit; i++) begin
            edge1();
            if (i == 1) rep_lo = 1'b0;
            if (i > 3 && int'(ph) == sel) hit = 1'b1;
            else if (clk_adapt !== 1'b0) ok = 1'b0;
            if (i == 3) sel = (int'(ph) + 1) % 16;
        end
        check(ok && hit && clk_adapt === 1'b1, "R3 rise", int'(clk_adapt), 1);
    endtask

    initial begin
        #400000;
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int oh, ol;
        bit ok;
        hi_cfg = {7'd127, 7'd90, 7'd40, 7'd2};
        lo_cfg = {7'd64, 7'd3, 7'd127, 7'd10};
        repeat (3) edge1();
        check(clk_adapt === 1'b0 && wd_error === 1'b0, "R1 reset outputs", int'(clk_adapt), 0);
        @(negedge clk); rst_n = 1'b1;
        edge1();
        check(clk_adapt === 1'b0 && wd_error === 1'b0, "R1 after release", int'(wd_error), 0);
        check(hi_code == 7'd124 && lo_code == 7'd124, "R1 codes", int'(hi_code), 124);

        do_rise();
        for (int m = 0; m < 4; m++) begin
            for (int d = 1; d <= 3; d++) begin
                ph_div = d;
                oh = int'(hi_code); ol = int'(lo_code);
                mode = 2'(m);
                repeat (4) edge1();
                check(int'(hi_code) == oh && int'(lo_code) == ol && clk_adapt === 1'b1,
                      "R5 hold while high", int'(hi_code), oh);
                do_fall();
                do_rise();
            end
        end

        // R4: wrong-kind pulses ignored
        oh = int'(hi_code);
        @(negedge clk); rep_lo = 1'b1; edge1(); rep_lo = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin edge1(); if (clk_adapt !== 1'b1) ok = 1'b0; end
        check(ok, "R4 low pulse while high", int'(clk_adapt), 1);
        mode = 2'd1;
        do_fall();
        oh = int'(hi_code); ol = int'(lo_code);
        mode = 2'd2;
        @(negedge clk); rep_hi = 1'b1; edge1(); rep_hi = 1'b0;
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin edge1(); if (clk_adapt !== 1'b0) ok = 1'b0; end
        check(ok && int'(hi_code) == oh && int'(lo_code) == ol, "R4 high pulse while low",
              int'(hi_code), oh);
        do_rise();

        // R9: watchdog disabled
        wd_limit = 16'd0;
        ok = 1'b1;
        for (int i = 0; i < 300; i++) begin edge1(); if (clk_adapt !== 1'b1 || wd_error !== 1'b0) ok = 1'b0; end
        check(ok, "R9 disabled watchdog", int'(wd_error), 0);
        wd_limit = 16'd1000;
        do_fall();
        do_rise();

        // R7 stuck high, L = 20
        wd_limit = 16'd20;
        mode = 2'd3;
        for (int j = 1; j <= 22; j++) begin
            edge1();
            if (j == 20) check(clk_adapt === 1'b1 && wd_error === 1'b0, "R7 before timeout", int'(wd_error), 0);
            if (j == 21) begin
                check(clk_adapt === 1'b0 && wd_error === 1'b1, "R7 forced low", int'(clk_adapt), 0);
                check(int'(hi_code) == exp_hi(3), "R5 reload on forced fall", int'(hi_code), exp_hi(3));
            end
            if (j == 22) check(clk_adapt === 1'b1, "R7 forced rise", int'(clk_adapt), 1);
        end

        // R8 sticky
        wd_limit = 16'd1000;
        do_fall();
        do_rise();
        check(wd_error === 1'b1, "R8 sticky", int'(wd_error), 1);

        // R7 frozen phase while waiting to rise
        wd_limit = 16'd20;
        @(negedge clk); rep_hi = 1'b1;
        for (int j = 1; j <= 22; j++) begin
            edge1();
            if (j == 1) rep_hi = 1'b0;
            if (j == 3) begin
                check(clk_adapt === 1'b0, "R2 fall before freeze", int'(clk_adapt), 0);
                rep_lo = 1'b1;
            end
            if (j == 4) begin rep_lo = 1'b0; ph_run = 1'b0; end
            if (j == 21) check(clk_adapt === 1'b0, "R7 stalled phase low", int'(clk_adapt), 0);
            if (j == 22) check(clk_adapt === 1'b1, "R7 stalled phase forced rise", int'(clk_adapt), 1);
        end
        ph_run = 1'b1;

        // R1 / R8: reset clears the error
        @(negedge clk); rst_n = 1'b0;
        repeat (2) edge1();
        @(negedge clk); rst_n = 1'b1;
        edge1();
        check(wd_error === 1'b0 && clk_adapt === 1'b0, "R1 error cleared by reset", int'(wd_error), 0);
        check(hi_code == 7'd124 && lo_code == 7'd124, "R1 codes after reset", int'(lo_code), 124);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule